// File: doc/BRIEF.md
# Peripheral Register Page Stack

This block holds the page selector for a banked special-register space in a small 8-bit controller. The selector is the top entry of a three-entry hardware stack: a current page, a "next" page and a "last" page. When the core accepts an interrupt, the stack shifts down. If automatic paging is enabled, the current page also switches to the page that holds the interrupting peripheral's registers. A return from interrupt shifts the stack up and restores the page that was saved.

Software reaches all three entries and an automatic-paging control register through a byte-wide register port. These addresses are decoded on every page. A software write changes one entry in place and never shifts the stack. The current page is driven out continuously to the register address decoder. Every interface is a plain strobe or level. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure: a strobe is acted on in the cycle it is seen.

Top module: `regpage_top`

## Requirements
- R1: After reset the current, next and last entries read 0x00, the control register reads 0x01 (automatic paging on) and `cur_page` is 0x00.
- R2: The current, next and last entries are read and written at addresses 0x84, 0x85 and 0x86, and the control register at 0x8F. `reg_hit` is 1 exactly for these four addresses, and the read value does not depend on `cur_page`.
- R3: When `irq_accept` is high at a clock edge, the last entry takes the old next value and the next entry takes the old current value. The old last value is discarded.
- R4: On that same edge, the current entry takes `irq_page` if control bit 0 is 1. If the bit is 0, the current entry keeps its value.
- R5: When `reti` is high at an edge and `irq_accept` is low, the current entry takes the old next value and the next entry takes the old last value. The last entry is unchanged.
- R6: A register write with no strobe replaces only the addressed entry, from the next cycle on. The other two entries do not move.
- R7: Control bit 0 is read/write. Bits 7..1 always read 0 and writes to them have no effect.
- R8: A register write issued in a cycle where `irq_accept` or `reti` is high is discarded. This holds for every address, including the control register.
- R9: If `irq_accept` and `reti` are both high at one edge, only the push of R3/R4 happens.
- R10: `cur_page` always equals the value read from address 0x84.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register port address |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` (0 when no hit) |
| reg_hit | output | 1 | `reg_addr` selects one of this block's registers |
| irq_accept | input | 1 | One-cycle strobe: an interrupt is being entered |
| irq_page | input | 8 | Page of the interrupting source, valid with `irq_accept` |
| reti | input | 1 | One-cycle strobe: a return from interrupt |
| cur_page | output | 8 | Current page, driven to the register address decoder |

## Verification
The assertions assume that `irq_page` is a known value whenever `irq_accept` is high, and that both strobes stay low while reset is asserted. The bench drives every input only at the falling clock edge and holds reset for several cycles with all strobes at 0. Random traffic can raise `irq_accept`, `reti` and `reg_wr` in the same cycle, so the priority rules are exercised on purpose. It also nests pushes deeper than three entries, which relies on the defined loss of the last entry and not on any overflow guard.

// File: rtl/regpage_pkg.sv
package regpage_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int DEPTH      = 3;
  localparam int ENTRY_BASE = 'h84;
  localparam int CTRL_ADDR  = 'h8F;
  localparam logic CTRL_RESET = 1'b1;

  typedef enum logic [1:0] {
    STK_HOLD = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/regpage_decode.sv
module regpage_decode
  import regpage_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int NENT  = DEPTH,
  parameter int BASE  = ENTRY_BASE,
  parameter int CADDR = CTRL_ADDR
) (
  input  logic [AW-1:0]   addr,
  output logic [NENT-1:0] ent_sel,
  output logic            ctrl_sel,
  output logic            hit
);
  localparam logic [AW-1:0] CTRL_A = AW'(CADDR);

  for (genvar i = 0; i < NENT; i++) begin : g_sel
    localparam logic [AW-1:0] ENT_A = AW'(BASE + i);
    assign ent_sel[i] = (addr == ENT_A);
  end

  assign ctrl_sel = (addr == CTRL_A);
  assign hit      = ctrl_sel | (|ent_sel);
endmodule

// File: rtl/regpage_ctrl.sv
module regpage_ctrl
  import regpage_pkg::*;
#(
  parameter logic RST_VAL = CTRL_RESET
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic auto_en
);
  always_ff @(posedge clk) begin
    if (!rst_n)     auto_en <= RST_VAL;
    else if (wr_en) auto_en <= wr_bit;
  end
endmodule

// File: rtl/regpage_stack.sv
module regpage_stack
  import regpage_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int NENT = DEPTH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  stk_op_e                  op,
  input  logic                     auto_en,
  input  logic [DW-1:0]            push_page,
  input  logic [NENT-1:0]          wr_sel,
  input  logic [DW-1:0]            wdata,
  output logic [NENT-1:0][DW-1:0]  ent
);
  for (genvar i = 0; i < NENT; i++) begin : g_ent
    logic [DW-1:0] push_val, pop_val;

    if (i == 0) begin : g_top
      assign push_val = auto_en ? push_page : ent[0];
    end else begin : g_lower
      assign push_val = ent[i-1];
    end

    if (i == NENT-1) begin : g_bottom
      assign pop_val = ent[i];
    end else begin : g_upper
      assign pop_val = ent[i+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent[i] <= '0;
      end else begin
        unique case (op)
          STK_PUSH: ent[i] <= push_val;
          STK_POP:  ent[i] <= pop_val;
          default:  if (wr_sel[i]) ent[i] <= wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/regpage_top.sv
module regpage_top
  import regpage_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int NENT  = DEPTH,
  parameter int BASE  = ENTRY_BASE,
  parameter int CADDR = CTRL_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_hit,
  input  logic          irq_accept,
  input  logic [DW-1:0] irq_page,
  input  logic          reti,
  output logic [DW-1:0] cur_page
);
  logic [NENT-1:0]         ent_sel;
  logic                    ctrl_sel;
  logic                    auto_en;
  logic                    wr_ok;
  stk_op_e                 op;
  logic [NENT-1:0][DW-1:0] ent_q;

  regpage_decode #(.AW(AW), .NENT(NENT), .BASE(BASE), .CADDR(CADDR)) u_dec (
    .addr(reg_addr), .ent_sel(ent_sel), .ctrl_sel(ctrl_sel), .hit(reg_hit)
  );

  // Strobes outrank software writes; a push outranks a pop.
  always_comb begin
    if (irq_accept) op = STK_PUSH;
    else if (reti)  op = STK_POP;
    else            op = STK_HOLD;
  end
  assign wr_ok = reg_wr & (op == STK_HOLD);

  regpage_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ok & ctrl_sel),
    .wr_bit(reg_wdata[0]), .auto_en(auto_en)
  );

  regpage_stack #(.DW(DW), .NENT(NENT)) u_stk (
    .clk(clk), .rst_n(rst_n), .op(op), .auto_en(auto_en),
    .push_page(irq_page), .wr_sel(ent_sel & {NENT{wr_ok}}),
    .wdata(reg_wdata), .ent(ent_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (ctrl_sel) reg_rdata = DW'(auto_en);
    for (int i = 0; i < NENT; i++)
      if (ent_sel[i]) reg_rdata = ent_q[i];
  end

  assign cur_page = ent_q[0];
endmodule

// File: rtl/regpage_sva.sv
module regpage_sva #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr,
  input logic [DW-1:0] reg_rdata,
  input logic          irq_accept,
  input logic [DW-1:0] irq_page,
  input logic          reti,
  input logic [DW-1:0] cur_page,
  input logic          auto_en,
  input logic [DW-1:0] next_pg,
  input logic [DW-1:0] last_pg
);
  p_push_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> (next_pg == $past(cur_page)) && (last_pg == $past(next_pg)));

  p_push_auto_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> cur_page == ($past(auto_en) ? $past(irq_page) : $past(cur_page)));

  p_pop_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_accept) |=> (cur_page == $past(next_pg)) && (next_pg == $past(last_pg)));

  p_pop_keeps_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !irq_accept) |=> $stable(last_pg));

  p_quiet_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_accept && !reti && !reg_wr) |=> $stable(cur_page) && $stable(next_pg) && $stable(last_pg));

  p_ctrl_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'('h8F)) |-> (reg_rdata[DW-1:1] == '0));

  p_write_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reti && !irq_accept) |=> $stable(last_pg) && $stable(auto_en));

  p_cur_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'('h84)) |-> (reg_rdata == cur_page));
endmodule

bind regpage_top regpage_sva #(.DW(DW), .AW(AW)) u_sva (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_rdata(reg_rdata), .irq_accept(irq_accept), .irq_page(irq_page),
  .reti(reti), .cur_page(cur_page), .auto_en(auto_en),
  .next_pg(ent_q[1]), .last_pg(ent_q[2])
);

// File: tb/regpage_top_tb_top.sv
module regpage_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_hit;
  logic       irq_accept = 1'b0;
  logic [7:0] irq_page = '0;
  logic       reti = 1'b0;
  logic [7:0] cur_page;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_cur, m_nxt, m_lst;
  logic       m_auto;

  always #10 clk = ~clk;

  regpage_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_hit(reg_hit),
    .irq_accept(irq_accept), .irq_page(irq_page), .reti(reti), .cur_page(cur_page)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_read(logic [7:0] a);
    case (a)
      8'h84:   return {1'b1, m_cur};
      8'h85:   return {1'b1, m_nxt};
      8'h86:   return {1'b1, m_lst};
      8'h8F:   return {1'b1, 7'd0, m_auto};
      default: return 9'd0;
    endcase
  endfunction

  // One clock: drive at the falling edge, update the model, check after the rising edge.
  task automatic step(logic wr, logic [7:0] a, logic [7:0] d,
                      logic acc, logic [7:0] pg, logic ret, string req);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    irq_accept = acc; irq_page = pg; reti = ret;
    @(posedge clk);
    if (acc) begin
      m_lst = m_nxt; m_nxt = m_cur;
      if (m_auto) m_cur = pg;
    end else if (ret) begin
      m_cur = m_nxt; m_nxt = m_lst;
    end else if (wr) begin
      case (a)
        8'h84: m_cur = d;
        8'h85: m_nxt = d;
        8'h86: m_lst = d;
        8'h8F: m_auto = d[0];
        default: ;
      endcase
    end
    @(negedge clk);
    reg_wr = 1'b0; irq_accept = 1'b0; reti = 1'b0;
    check(req, cur_page, m_cur);
  endtask

  task automatic rd(logic [7:0] a, string req);
    logic [8:0] e;
    reg_addr = a; reg_wr = 1'b0; irq_accept = 1'b0; reti = 1'b0;
    #1;
    e = exp_read(a);
    check(req, {7'd0, reg_hit}, {7'd0, e[8]});
    check(req, reg_rdata, e[7:0]);
  endtask

  task automatic rd_all(string req);
    rd(8'h84, req); rd(8'h85, req); rd(8'h86, req); rd(8'h8F, req);
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    m_cur = '0; m_nxt = '0; m_lst = '0; m_auto = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", cur_page, 8'h00);
    rd_all("R1");
    rd(8'h83, "R2"); rd(8'h87, "R2"); rd(8'h04, "R2");

    // R6: in-place writes, no shift
    step(1, 8'h84, 8'h11, 0, 0, 0, "R6");
    step(1, 8'h85, 8'h22, 0, 0, 0, "R6");
    step(1, 8'h86, 8'h33, 0, 0, 0, "R6");
    rd_all("R6");
    rd(8'h84, "R10"); check("R10", reg_rdata, cur_page);
    // R2: page-independent decode
    step(1, 8'h84, 8'h0F, 0, 0, 0, "R2");
    rd_all("R2");
    // R3/R4: push with auto paging on
    step(0, 0, 0, 1, 8'h5A, 0, "R4");
    rd_all("R3");
    // R7: reserved bits
    step(1, 8'h8F, 8'hFE, 0, 0, 0, "R7");
    rd(8'h8F, "R7");
    // R4: push with auto paging off keeps page
    step(0, 0, 0, 1, 8'hA5, 0, "R4");
    rd_all("R4");
    step(1, 8'h8F, 8'h01, 0, 0, 0, "R7");
    rd(8'h8F, "R7");
    // R5: pops
    step(0, 0, 0, 0, 0, 1, "R5");
    rd_all("R5");
    step(0, 0, 0, 0, 0, 1, "R5");
    rd_all("R5");
    // R8: writes dropped under strobes
    step(1, 8'h86, 8'hEE, 0, 0, 1, "R8");
    rd_all("R8");
    step(1, 8'h8F, 8'h00, 1, 8'h44, 0, "R8");
    rd_all("R8");
    // R9: push wins over pop
    step(0, 0, 0, 1, 8'h77, 1, "R9");
    rd_all("R9");

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a;
      logic [2:0] sel;
      sel = 3'($urandom_range(0, 5));
      case (sel)
        3'd0: a = 8'h84;
        3'd1: a = 8'h85;
        3'd2: a = 8'h86;
        3'd3: a = 8'h8F;
        default: a = 8'($urandom);
      endcase
      step($urandom_range(0, 2) == 0, a, 8'($urandom),
           $urandom_range(0, 3) == 0, 8'($urandom),
           $urandom_range(0, 3) == 0, "R10");
      if (n % 4 == 0) rd_all("R3");
      else rd(8'($urandom), "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule